// File: doc/BRIEF.md
# Serial Link Controller with Interrupt Lines

This block is a compact asynchronous serial transceiver meant to sit behind a pin-limited chip wrapper. Bytes for transmission arrive as a 7-bit parallel word. The word is placed in the upper seven bits of the byte, and the lowest bit is zero. A write strobe pushes the byte into a small transmit queue. Once the transmitter is enabled and its load gate is open, queued bytes are framed and shifted out on the serial line. The frame is a low start bit, eight data bits with bit 0 first, an even-parity bit and a high stop bit.

On the receive side, a two-flop synchroniser feeds an oversampling receiver. The receiver rejects short start glitches and checks both the parity bit and the stop bit. Good bytes go into a small receive queue, whose oldest entry is shown on the parallel output. A read acknowledge discards that entry.

Bit timing comes from a fixed clock divider of 32. In normal mode each bit lasts 16 divider ticks (512 clocks). In bypass mode the oversampling stage is skipped and each bit lasts one tick (32 clocks).

Four interrupt lines report these events:
- the transmit queue has space;
- the receive queue holds data;
- a transmitted frame has completed;
- a received frame has ended, whether good or in error.

Top module: `serial_link_core`

## Requirements
- R1: After the active-low reset, `txd` is 1, `tx_busy` is 0, `irq_tx_space` is 1, `irq_rx_avail` is 0, `rx_byte` is 0, and both pulse interrupts are 0.
- R2: A transmitted frame is, in line order: start bit 0, data bits D0 to D7, parity bit, stop bit 1. The parity bit is the XOR of the eight data bits (even parity). The data byte is `{tx_word, 1'b0}`.
- R3: With `clk_bypass`=0 a bit lasts 512 clocks (divider 32 times 16). With `clk_bypass`=1 a bit lasts 32 clocks.
- R4: A frame starts only when `tx_enable` and `tx_load` are both 1 and the transmit queue is not empty. Otherwise `txd` stays 1 and queued bytes are kept.
- R5: `tx_busy` is 1 for exactly the 11 bit periods of a frame, starting in the cycle the start bit appears.
- R6: `irq_tx_done` is a single-cycle pulse in the first cycle after `tx_busy` falls.
- R7: The transmit queue holds 4 bytes. `irq_tx_space` is 0 while it is full, and a `tx_push` while full is ignored.
- R8: A good received byte appears on `rx_byte` with `irq_rx_avail`=1. Bytes are delivered oldest first. Each `rx_ack` cycle removes one byte. `rx_byte` reads 0 while the receive queue is empty.
- R9: A frame whose parity bit mismatches even parity is discarded and still pulses `irq_rx_event`.
- R10: A frame whose stop bit samples 0 is discarded and pulses `irq_rx_event`. The receiver then waits for the line to return to 1 before it looks for a new start bit.
- R11: `irq_rx_event` pulses for one cycle once per completed frame.
- R12: A low level on `rxd` that ends before the middle of the start bit produces no byte and no event.
- R13: The receive queue holds 4 bytes. A good frame that arrives while it is full is dropped, and the stored bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmitter enable |
| clk_bypass | input | 1 | 1 = skip 16x oversampling; change only while idle |
| tx_push | input | 1 | Push `{tx_word,0}` into the transmit queue |
| tx_load | input | 1 | Gate allowing the transmitter to take the next queued byte |
| rx_ack | input | 1 | Remove the byte shown on `rx_byte` |
| tx_word | input | 7 | Upper seven bits of the byte to send |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| rx_byte | output | 8 | Oldest received byte, 0 when none |
| tx_busy | output | 1 | Frame being shifted out |
| irq_tx_space | output | 1 | Transmit queue not full |
| irq_rx_avail | output | 1 | Receive queue not empty |
| irq_tx_done | output | 1 | Pulse: transmit frame complete |
| irq_rx_event | output | 1 | Pulse: receive frame ended (good or error) |

## Verification
The hardest cases to reach are the receive error paths. A looped-back transmitter can only produce correct frames, so it can never create a parity mismatch, a low stop bit or a truncated start bit. The bench therefore breaks the loop and drives `rxd` itself in bypass mode. It builds frames with a flipped parity bit, frames with a held-low stop bit, and an 8-clock start glitch, then checks `irq_rx_event` and the queue state at the ports. Receive-queue overflow is reached by pausing the scoreboard monitor, so that five looped frames pile up against four slots.

// File: rtl/uart_link_pkg.sv
package uart_link_pkg;
  localparam int unsigned BAUD_DIV   = 32;
  localparam int unsigned OVERSAMPLE = 16;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 3;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_BREAK
  } rx_state_t;

  // Even parity: the parity bit makes the count of ones even.
  function automatic logic even_parity(input logic [DATA_BITS-1:0] d);
    return ^d;
  endfunction

  // Line-order frame, bit 0 leaves first: start, data LSB first, parity, stop.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_BITS-1:0] d);
    return {1'b1, even_parity(d), d, 1'b0};
  endfunction
endpackage

// File: rtl/link_baud_div.sv
module link_baud_div #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic start_half,
  output logic tick
);
  localparam int unsigned CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt;

  // A restart realigns the phase; start_half puts the first tick half a period away.
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= start_half ? HALF : '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

  assign tick = (cnt == LAST) && !restart;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
endmodule

// File: rtl/link_fifo.sv
module link_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_SLOT  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LEVEL = CW'(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    level;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] next_slot(input logic [AW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + AW'(1);
  endfunction

  assign full    = (level == FULL_LEVEL);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_slot(wr_ptr);
      if (do_pop)  rd_ptr <= next_slot(rd_ptr);
      level <= level + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty); // R8
endmodule

// File: rtl/link_tx.sv
module link_tx
  import uart_link_pkg::*;
#(
  parameter int unsigned DIV = BAUD_DIV,
  parameter int unsigned OVS = OVERSAMPLE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 load,
  input  logic                 bypass,
  input  logic                 q_empty,
  input  logic [DATA_BITS-1:0] q_data,
  output logic                 q_pop,
  output logic                 txd,
  output logic                 busy,
  output logic                 done
);
  localparam int unsigned SW = $clog2(OVS);
  localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
  localparam int unsigned IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);

  logic                  start_frame, tick, bit_strobe, last_bit;
  logic [SW-1:0]         sub;
  logic [IW-1:0]         idx;
  logic [FRAME_BITS-1:0] shreg;
  logic                  busy_q, done_q;

  // Named events for the assertions below.
  assign start_frame = !busy_q && enable && load && !q_empty;
  assign q_pop       = start_frame;

  link_baud_div #(.DIV(DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start_frame),
    .start_half(1'b0),
    .tick      (tick)
  );

  assign bit_strobe = busy_q && tick && (bypass || (sub == SUB_LAST));
  assign last_bit   = bit_strobe && (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub    <= '0;
      idx    <= '0;
      shreg  <= '1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_bit;
      if (start_frame) begin
        sub    <= '0;
        idx    <= '0;
        shreg  <= build_frame(q_data);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (tick) sub <= (sub == SUB_LAST) ? '0 : sub + SW'(1);
        if (bit_strobe) begin
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
          idx   <= idx + IW'(1);
        end
        if (last_bit) busy_q <= 1'b0;
      end
    end
  end

  assign txd  = shreg[0];
  assign busy = busy_q;
  assign done = done_q;

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2
  AST_TX_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R2
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable && load)); // R4
  AST_TX_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy)); // R5
  AST_TX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
endmodule

// File: rtl/link_rx.sv
module link_rx
  import uart_link_pkg::*;
#(
  parameter int unsigned DIV = BAUD_DIV,
  parameter int unsigned OVS = OVERSAMPLE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 bypass,
  input  logic                 q_full,
  output logic                 q_push,
  output logic [DATA_BITS-1:0] q_data,
  output logic                 frame_end
);
  localparam int unsigned SW = $clog2(OVS);
  localparam logic [SW-1:0] START_MID = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] SUB_LAST  = SW'(OVS - 1);
  localparam int unsigned BW = $clog2(DATA_BITS);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_BITS - 1);

  rx_state_t            state;
  logic                 rx_meta, rx_s;
  logic [SW-1:0]        sub;
  logic [BW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_bit, ev_q;
  logic                 arm, tick, hunting, sample, stop_sample;
  logic                 parity_err, frame_err;

  // Two-flop synchroniser, idle high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rxd;
      rx_s    <= rx_meta;
    end
  end

  assign arm = (state == RX_IDLE) && !rx_s;

  // Restart puts the first bypass-mode tick in mid start bit.
  link_baud_div #(.DIV(DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (arm),
    .start_half(bypass),
    .tick      (tick)
  );

  assign hunting     = state inside {RX_START, RX_DATA, RX_PARITY, RX_STOP};
  assign sample      = hunting && tick &&
                       (bypass || (sub == ((state == RX_START) ? START_MID : SUB_LAST)));
  assign stop_sample = sample && (state == RX_STOP);
  assign parity_err  = (par_bit != even_parity(shreg));
  assign frame_err   = stop_sample && !rx_s;
  assign q_push      = stop_sample && !frame_err && !parity_err && !q_full;
  assign q_data      = shreg;
  assign frame_end   = ev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      sub     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      ev_q <= stop_sample;
      if (arm)       sub <= '0;
      else if (tick) sub <= sample ? '0 : sub + SW'(1);
      unique case (state)
        RX_IDLE:   if (arm) state <= RX_START;
        RX_START:  if (sample) begin
                     state <= rx_s ? RX_IDLE : RX_DATA;
                     idx   <= '0;
                   end
        RX_DATA:   if (sample) begin
                     shreg <= {rx_s, shreg[DATA_BITS-1:1]};
                     idx   <= idx + BW'(1);
                     if (idx == BIT_LAST) state <= RX_PARITY;
                   end
        RX_PARITY: if (sample) begin
                     par_bit <= rx_s;
                     state   <= RX_STOP;
                   end
        RX_STOP:   if (sample) state <= rx_s ? RX_IDLE : RX_BREAK;
        RX_BREAK:  if (rx_s) state <= RX_IDLE;
        default:   state <= RX_IDLE;
      endcase
    end
  end

  AST_RX_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end); // R11
  AST_RX_PUSH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> frame_end); // R11
  AST_RX_BREAK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_BREAK && !rx_s) |=> state == RX_BREAK); // R10
endmodule

// File: rtl/serial_link_core.sv
module serial_link_core
  import uart_link_pkg::*;
#(
  parameter int unsigned DIV       = BAUD_DIV,
  parameter int unsigned OVS       = OVERSAMPLE,
  parameter int unsigned TXQ_DEPTH = 4,
  parameter int unsigned RXQ_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_enable,
  input  logic                 clk_bypass,
  input  logic                 tx_push,
  input  logic                 tx_load,
  input  logic                 rx_ack,
  input  logic [DATA_BITS-2:0] tx_word,
  input  logic                 rxd,
  output logic                 txd,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 tx_busy,
  output logic                 irq_tx_space,
  output logic                 irq_rx_avail,
  output logic                 irq_tx_done,
  output logic                 irq_rx_event
);
  logic [DATA_BITS-1:0] tx_byte, txq_head, rx_data, rxq_head;
  logic                 txq_full, txq_empty, txq_pop;
  logic                 rxq_full, rxq_empty, rx_push;

  // Parallel word is MSB-aligned; the unused LSB is zero.
  assign tx_byte = {tx_word, 1'b0};

  link_fifo #(.WIDTH(DATA_BITS), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_byte), .pop(txq_pop),
    .dout(txq_head), .full(txq_full), .empty(txq_empty)
  );

  link_tx #(.DIV(DIV), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(tx_enable), .load(tx_load), .bypass(clk_bypass),
    .q_empty(txq_empty), .q_data(txq_head), .q_pop(txq_pop),
    .txd(txd), .busy(tx_busy), .done(irq_tx_done)
  );

  link_rx #(.DIV(DIV), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .bypass(clk_bypass), .q_full(rxq_full),
    .q_push(rx_push), .q_data(rx_data), .frame_end(irq_rx_event)
  );

  link_fifo #(.WIDTH(DATA_BITS), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data), .pop(rx_ack),
    .dout(rxq_head), .full(rxq_full), .empty(rxq_empty)
  );

  assign rx_byte      = rxq_empty ? '0 : rxq_head;
  assign irq_tx_space = !txq_full;
  assign irq_rx_avail = !rxq_empty;

  AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_full && !rx_ack) |=> $stable(rx_byte)); // R13
endmodule

// File: tb/serial_link_core_test.sv
`timescale 1ns/1ps
module serial_link_core_test;
  localparam int P16 = 32 * 16;
  localparam int PBY = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       tx_enable = 0, clk_bypass = 0, tx_push = 0, tx_load = 0;
  logic       tb_ack = 0, mon_ack = 0, rx_drv = 1, loop_sel = 1, mon_en = 1;
  logic [6:0] tx_word = '0;
  logic       txd, tx_busy, irq_tx_space, irq_rx_avail, irq_tx_done, irq_rx_event;
  logic [7:0] rx_byte;
  logic       rxd, rx_ack;

  assign rxd    = loop_sel ? txd : rx_drv;
  assign rx_ack = tb_ack | mon_ack;

  serial_link_core uut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .clk_bypass(clk_bypass),
    .tx_push(tx_push), .tx_load(tx_load), .rx_ack(rx_ack), .tx_word(tx_word),
    .rxd(rxd), .txd(txd), .rx_byte(rx_byte), .tx_busy(tx_busy),
    .irq_tx_space(irq_tx_space), .irq_rx_avail(irq_rx_avail),
    .irq_tx_done(irq_tx_done), .irq_rx_event(irq_rx_event)
  );

  int errors = 0, checks = 0, done_cnt = 0, ev_cnt = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] e_byte;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ones(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    return n;
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] b);
    logic p = (ones(b) % 2) == 1;
    return {1'b1, p, b, 1'b0};
  endfunction

  // Pulse interrupt counters
  always @(posedge clk) begin
    if (irq_tx_done)  done_cnt++;
    if (irq_rx_event) ev_cnt++;
  end

  // Scoreboard monitor: compares each delivered byte with the queue head, then acks it.
  always @(negedge clk) begin
    if (mon_ack) mon_ack = 1'b0;
    else if (rst_n && mon_en && irq_rx_avail) begin
      if (exp_q.size() == 0) chk("R8 unexpected byte", rx_byte, 'h1FF);
      else begin
        e_byte = exp_q.pop_front();
        chk("R8 loopback byte", rx_byte, e_byte);
      end
      mon_ack = 1'b1;
    end
  end

  task automatic push_word(input logic [6:0] w, input bit expect_it);
    @(negedge clk); tx_word = w; tx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0;
    if (expect_it) exp_q.push_back({w, 1'b0});
  endtask

  task automatic wait_idle();
    while (tx_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_drain(input int limit);
    int n = 0;
    while ((exp_q.size() != 0 || irq_rx_avail) && n < limit) begin
      @(negedge clk); n++;
    end
    chk("R8 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic capture_frame(input int per, output logic [10:0] bits);
    while (txd) @(negedge clk);
    repeat (per / 2) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < 11; i++) begin
      repeat (per) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  // Counts busy cycles and the initial low run (start + D0, since D0 is always 0).
  task automatic measure(input int per, input string tag);
    int n_busy = 0, n_low = 0;
    bit low_phase = 1;
    int d0 = done_cnt;
    while (!tx_busy) @(negedge clk);
    while (tx_busy) begin
      n_busy++;
      if (low_phase && !txd) n_low++; else low_phase = 0;
      @(negedge clk);
    end
    chk({"R3 low run ", tag}, n_low, 2 * per);
    chk({"R5 busy length ", tag}, n_busy, 11 * per);
    chk({"R6 done pulse high ", tag}, irq_tx_done, 1);
    @(negedge clk);
    chk({"R6 done pulse ends ", tag}, irq_tx_done, 0);
    chk({"R6 one done pulse ", tag}, done_cnt - d0, 1);
  endtask

  task automatic send_raw(input logic [7:0] b, input bit bad_par, input bit stop_v);
    logic [10:0] f = exp_frame(b);
    f[9]  = f[9] ^ bad_par;
    f[10] = stop_v;
    for (int i = 0; i < 11; i++) begin
      rx_drv = f[i];
      repeat (PBY) @(negedge clk);
    end
  endtask

  initial begin
    logic [10:0] bits;
    logic [7:0]  held [4];
    int e0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd idle", txd, 1);
    chk("R1 busy", tx_busy, 0);
    chk("R1 tx space", irq_tx_space, 1);
    chk("R1 rx avail", irq_rx_avail, 0);
    chk("R1 rx byte", rx_byte, 0);
    chk("R1 pulses", {irq_tx_done, irq_rx_event}, 0);

    // Gating in 16x mode
    push_word(7'h35, 1);
    repeat (1200) @(negedge clk);
    chk("R4 disabled line", txd, 1);
    chk("R4 disabled busy", tx_busy, 0);
    tx_enable = 1'b1;
    repeat (1200) @(negedge clk);
    chk("R4 load low busy", tx_busy, 0);
    tx_load = 1'b1;
    capture_frame(P16, bits);
    chk("R2 frame bits 0x6A", bits, exp_frame(8'h6A));
    wait_drain(8000);

    // Timing, 16x then bypass
    wait_idle();
    push_word(7'h7F, 1);
    measure(P16, "16x");
    wait_drain(8000);
    wait_idle();
    clk_bypass = 1'b1;
    push_word(7'h7F, 1);
    measure(PBY, "bypass");
    wait_drain(2000);

    // Several loopback patterns
    e0 = ev_cnt;
    push_word(7'h00, 1);
    push_word(7'h2A, 1);
    push_word(7'h55, 1);
    push_word(7'h4C, 1);
    wait_drain(4000);
    chk("R11 events per frame", ev_cnt - e0, 4);

    // Transmit queue full
    wait_idle();
    tx_enable = 1'b0;
    push_word(7'h01, 1);
    push_word(7'h02, 1);
    push_word(7'h03, 1);
    push_word(7'h04, 1);
    chk("R7 space low when full", irq_tx_space, 0);
    push_word(7'h05, 0);
    tx_enable = 1'b1;
    wait_drain(4000);
    repeat (800) @(negedge clk);
    chk("R7 fifth push dropped", irq_rx_avail, 0);

    // Receive queue overflow, monitor paused
    mon_en = 1'b0;
    e0 = ev_cnt;
    for (int i = 0; i < 5; i++) begin
      logic [6:0] w = 7'(8'h11 * (i + 1));
      if (i < 4) held[i] = {w, 1'b0};
      push_word(w, 0);
    end
    repeat (6 * 360 + 200) @(negedge clk);
    chk("R11 five events", ev_cnt - e0, 5);
    for (int i = 0; i < 4; i++) begin
      chk("R13 held byte order", rx_byte, held[i]);
      tb_ack = 1'b1; @(negedge clk); tb_ack = 1'b0;
    end
    chk("R8 empty after acks", irq_rx_avail, 0);
    chk("R8 byte zero when empty", rx_byte, 0);
    mon_en = 1'b1;

    // Receive error paths via direct line drive (bypass)
    wait_idle();
    loop_sel = 1'b0;
    repeat (40) @(negedge clk);
    e0 = ev_cnt;
    exp_q.push_back(8'hC3);
    send_raw(8'hC3, 0, 1);
    wait_drain(200);
    chk("R11 good raw frame event", ev_cnt - e0, 1);

    e0 = ev_cnt;
    send_raw(8'hC3, 1, 1);
    repeat (64) @(negedge clk);
    chk("R9 parity error event", ev_cnt - e0, 1);
    chk("R9 parity error discarded", irq_rx_avail, 0);

    e0 = ev_cnt;
    send_raw(8'h5A, 0, 0);
    repeat (3 * PBY) @(negedge clk);
    rx_drv = 1'b1;
    repeat (150) @(negedge clk);
    chk("R10 framing error event once", ev_cnt - e0, 1);
    chk("R10 framing error discarded", irq_rx_avail, 0);

    e0 = ev_cnt;
    rx_drv = 1'b0;
    repeat (8) @(negedge clk);
    rx_drv = 1'b1;
    repeat (200) @(negedge clk);
    chk("R12 glitch no event", ev_cnt - e0, 0);
    chk("R12 glitch no byte", irq_rx_avail, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule